// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block tracks the operating power mode of a small microcontroller and gates its clock domains to match. In normal operation the device runs in high-speed, medium-speed or subactive mode. When the CPU issues a sleep request in high-speed or subactive mode, and three control bits select watch operation, the controller parks the device in watch mode. In watch mode only the watchdog timer domain keeps its clock, and all other state is held.

A qualified wake event ends watch mode. The event may be the non-maskable interrupt, an enabled external interrupt line, or the watchdog overflow interrupt when that interrupt is enabled and not masked by the CPU. If the low-speed-select bit is set, the device resumes directly in subactive mode. Otherwise the controller waits out a programmable oscillator settling count, restores full clocks in high-speed or medium-speed mode, and strobes the interrupt-start output. The standby pin and the reset input override every other event.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high and `stby_n_i` is high, the next edge sets `mode_o` to 0 (high-speed), raises all three clock enables and clears `irq_start_o`.
- R2: In mode 0 (high-speed) or mode 2 (subactive), a `sleep_req_i` pulse with `stby_sel_i`=1, `direct_xfer_i`=0 and `wdt_clk_sel_i`=1 moves `mode_o` to 3 (watch) on the next edge.
- R3: In mode 3 (watch) and mode 4 (settling), `cpu_clk_en_o` and `periph_clk_en_o` are 0 and `wdt_clk_en_o` is 1. In modes 0, 1 and 2, all three enables are 1.
- R4: A sleep request that fails any of the three bit conditions, or that arrives in mode 1 (medium-speed), leaves `mode_o` unchanged.
- R5: In watch mode, a wake event is `nmi_i`, or `ext_irq_i[i]` with `ext_irq_en_i[i]`=1, or `wdt_ovf_i` with `wdt_ovf_en_i`=1 and `irq_mask_i`=0. Any other input combination keeps the mode at 3.
- R6: A wake event with `low_spd_sel_i`=1 moves `mode_o` to 2 (subactive) on the next edge. `irq_start_o` is high for exactly that one cycle.
- R7: A wake event with `low_spd_sel_i`=0 moves `mode_o` to 4 (settling) for N cycles. N depends on `settle_sel_i` values 0 through 7 as follows: 8, 32, 128, 512, 1024, 2048, 8192, 16384. The controller then enters the target mode with `irq_start_o` high for one cycle.
- R8: The settling target is mode 1 (medium-speed) if `med_sel_i` was 1 at the wake edge, and mode 0 (high-speed) otherwise.
- R9: `stby_n_i` low at an edge forces `mode_o` to 5 (hardware standby) from any mode, with all clock enables 0. Mode 5 is left only through reset while `stby_n_i` is high.
- R10: Reset in watch or settling mode returns to mode 0 with no interrupt-start pulse.
- R11: Priority at an edge is: standby pin first, then reset, then wake events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (reset pin path) |
| stby_n_i | input | 1 | Standby pin, active low |
| sleep_req_i | input | 1 | Sleep request from the CPU |
| stby_sel_i | input | 1 | Standby-select control bit |
| direct_xfer_i | input | 1 | Direct-transfer control bit |
| wdt_clk_sel_i | input | 1 | Watchdog clock-select control bit |
| low_spd_sel_i | input | 1 | Resume to subactive when 1 |
| med_sel_i | input | 1 | Resume to medium-speed instead of high-speed |
| settle_sel_i | input | 3 | Oscillator settling count select |
| nmi_i | input | 1 | Non-maskable interrupt |
| wdt_ovf_i | input | 1 | Watchdog overflow interrupt request |
| wdt_ovf_en_i | input | 1 | Watchdog overflow interrupt enable |
| irq_mask_i | input | 1 | CPU interrupt mask for peripheral sources |
| ext_irq_i | input | NUM_EXT | External interrupt lines (lines 0, 1, 2, 6, 7) |
| ext_irq_en_i | input | NUM_EXT | Per-line external interrupt enables |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| wdt_clk_en_o | output | 1 | Watchdog domain clock enable |
| mode_o | output | 3 | Current mode code |
| irq_start_o | output | 1 | One-cycle interrupt-start strobe |

## Verification
Three events can land on the same edge: a wake event, reset, and a low level on the standby pin. The bench raises a qualified wake source together with `rst`, then together with a low `stby_n_i`, and finally drives reset and standby together. A behavioural reference model applies the stated priority, and its mode, clock enables and strobe are compared with the design's on every clock. The bench also checks at the ports that a wake paired with reset leaves `irq_start_o` low.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_HIGH   = 3'd0,
        PM_MED    = 3'd1,
        PM_SUB    = 3'd2,
        PM_WATCH  = 3'd3,
        PM_SETTLE = 3'd4,
        PM_HWSTBY = 3'd5
    } pm_mode_e;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic wdt;
    } clk_en_t;

    localparam int SETTLE_MAX = 16384;
    localparam int SETTLE_W   = $clog2(SETTLE_MAX + 1);

    // Settling length in reference-clock cycles for each select code.
    function automatic logic [SETTLE_W-1:0] settle_cycles(input logic [2:0] sel);
        logic [SETTLE_W-1:0] one;
        one = SETTLE_W'(1);
        case (sel)
            3'd0:    return one << 3;
            3'd1:    return one << 5;
            3'd2:    return one << 7;
            3'd3:    return one << 9;
            3'd4:    return one << 10;
            3'd5:    return one << 11;
            3'd6:    return one << 13;
            default: return one << 14;
        endcase
    endfunction

    function automatic logic watch_allowed(input logic ssel, input logic dxfer, input logic wsel);
        return ssel && !dxfer && wsel;
    endfunction

endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
    parameter int NUM_EXT = 5
) (
    input  logic               nmi_i,
    input  logic               wdt_ovf_i,
    input  logic               wdt_ovf_en_i,
    input  logic               irq_mask_i,
    input  logic [NUM_EXT-1:0] ext_irq_i,
    input  logic [NUM_EXT-1:0] ext_irq_en_i,
    output logic               wake_o
);
    logic [NUM_EXT-1:0] ext_hit;
    logic               periph_hit;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        assign ext_hit[i] = ext_irq_i[i] & ext_irq_en_i[i];
    end

    assign periph_hit = wdt_ovf_i & wdt_ovf_en_i & ~irq_mask_i;
    assign wake_o     = nmi_i | periph_hit | (|ext_hit);
endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    input  logic         run_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - W'(1);
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
    import pmc_pkg::*;
(
    input  pm_mode_e mode_i,
    output clk_en_t  en_o
);
    always_comb begin
        case (mode_i)
            PM_WATCH, PM_SETTLE: en_o = '{cpu: 1'b0, periph: 1'b0, wdt: 1'b1};
            PM_HWSTBY:           en_o = '{cpu: 1'b0, periph: 1'b0, wdt: 1'b0};
            default:             en_o = '{cpu: 1'b1, periph: 1'b1, wdt: 1'b1};
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_EXT = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stby_n_i,
    input  logic               sleep_req_i,
    input  logic               stby_sel_i,
    input  logic               direct_xfer_i,
    input  logic               wdt_clk_sel_i,
    input  logic               low_spd_sel_i,
    input  logic               med_sel_i,
    input  logic [2:0]         settle_sel_i,
    input  logic               nmi_i,
    input  logic               wdt_ovf_i,
    input  logic               wdt_ovf_en_i,
    input  logic               irq_mask_i,
    input  logic [NUM_EXT-1:0] ext_irq_i,
    input  logic [NUM_EXT-1:0] ext_irq_en_i,
    output logic               cpu_clk_en_o,
    output logic               periph_clk_en_o,
    output logic               wdt_clk_en_o,
    output logic [2:0]         mode_o,
    output logic               irq_start_o
);
    pm_mode_e state_q, state_d;
    pm_mode_e tgt_q, tgt_d;
    logic     irq_q, irq_d;
    logic     wake;
    logic     load;
    logic     settle_done;
    clk_en_t  en;

    pmc_wake_qual #(.NUM_EXT(NUM_EXT)) u_wake (
        .nmi_i        (nmi_i),
        .wdt_ovf_i    (wdt_ovf_i),
        .wdt_ovf_en_i (wdt_ovf_en_i),
        .irq_mask_i   (irq_mask_i),
        .ext_irq_i    (ext_irq_i),
        .ext_irq_en_i (ext_irq_en_i),
        .wake_o       (wake)
    );

    pmc_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .len_i  (settle_cycles(settle_sel_i)),
        .run_i  (state_q == PM_SETTLE),
        .done_o (settle_done)
    );

    pmc_clk_gate u_gate (
        .mode_i (state_q),
        .en_o   (en)
    );

    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        irq_d   = 1'b0;
        load    = 1'b0;
        case (state_q)
            PM_HIGH, PM_SUB: begin
                if (sleep_req_i && watch_allowed(stby_sel_i, direct_xfer_i, wdt_clk_sel_i))
                    state_d = PM_WATCH;
            end
            PM_WATCH: begin
                if (wake) begin
                    if (low_spd_sel_i) begin
                        state_d = PM_SUB;
                        irq_d   = 1'b1;
                    end else begin
                        state_d = PM_SETTLE;
                        load    = 1'b1;
                        tgt_d   = med_sel_i ? PM_MED : PM_HIGH;
                    end
                end
            end
            PM_SETTLE: begin
                if (settle_done) begin
                    state_d = tgt_q;
                    irq_d   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!stby_n_i) begin
            state_q <= PM_HWSTBY;
            irq_q   <= 1'b0;
        end else if (rst) begin
            state_q <= PM_HIGH;
            tgt_q   <= PM_HIGH;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            irq_q   <= irq_d;
        end
    end

    assign cpu_clk_en_o    = en.cpu;
    assign periph_clk_en_o = en.periph;
    assign wdt_clk_en_o    = en.wdt;
    assign mode_o          = state_q;
    assign irq_start_o     = irq_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk,
    input logic       rst,
    input logic       stby_n_i,
    input logic       sleep_req_i,
    input logic       stby_sel_i,
    input logic       direct_xfer_i,
    input logic       wdt_clk_sel_i,
    input logic       cpu_clk_en_o,
    input logic       periph_clk_en_o,
    input logic       wdt_clk_en_o,
    input logic [2:0] mode_o,
    input logic       irq_start_o
);
    // R2
    watch_entry_chk: assert property (@(posedge clk) disable iff (rst || !stby_n_i)
        (mode_o == 3'd3 && $past(mode_o) != 3'd3) |->
        $past(sleep_req_i && stby_sel_i && !direct_xfer_i && wdt_clk_sel_i));

    // R3
    watch_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd3 || mode_o == 3'd4) |-> (!cpu_clk_en_o && !periph_clk_en_o && wdt_clk_en_o));

    // R4
    med_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd1 && stby_n_i) |=> (mode_o == 3'd1));

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_start_o |=> !irq_start_o);

    // R7
    settle_exit_chk: assert property (@(posedge clk) disable iff (rst || !stby_n_i)
        (irq_start_o && mode_o != 3'd2) |-> ($past(mode_o) == 3'd4));

    // R9
    stby_force_chk: assert property (@(posedge clk) disable iff (rst)
        !stby_n_i |=> (mode_o == 3'd5 && !cpu_clk_en_o && !wdt_clk_en_o));
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .stby_n_i        (stby_n_i),
    .sleep_req_i     (sleep_req_i),
    .stby_sel_i      (stby_sel_i),
    .direct_xfer_i   (direct_xfer_i),
    .wdt_clk_sel_i   (wdt_clk_sel_i),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .wdt_clk_en_o    (wdt_clk_en_o),
    .mode_o          (mode_o),
    .irq_start_o     (irq_start_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int NE = 5;

    logic clk = 0;
    logic rst = 1, stby_n = 1, sleep = 0, ssel = 1, dxfer = 0, wsel = 1;
    logic lsel = 0, msel = 0, nmi = 0, ovf = 0, ovf_en = 0, mask = 0;
    logic [2:0] ssel_cnt = 0;
    logic [NE-1:0] ext = 0, ext_en = 0;
    logic cpu_en, per_en, wdt_en, irq;
    logic [2:0] mode;

    int n_chk = 0, n_fail = 0;
    string cur = "R1";
    bit finished = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.NUM_EXT(NE)) u0 (
        .clk(clk), .rst(rst), .stby_n_i(stby_n), .sleep_req_i(sleep),
        .stby_sel_i(ssel), .direct_xfer_i(dxfer), .wdt_clk_sel_i(wsel),
        .low_spd_sel_i(lsel), .med_sel_i(msel), .settle_sel_i(ssel_cnt),
        .nmi_i(nmi), .wdt_ovf_i(ovf), .wdt_ovf_en_i(ovf_en), .irq_mask_i(mask),
        .ext_irq_i(ext), .ext_irq_en_i(ext_en),
        .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en), .wdt_clk_en_o(wdt_en),
        .mode_o(mode), .irq_start_o(irq)
    );

    // Behavioural reference model.
    int m_mode = 0, m_cnt = 0, m_tgt = 0;
    bit m_irq = 0;
    int tbl[8] = '{8, 32, 128, 512, 1024, 2048, 8192, 16384};

    function automatic bit wake_ev();
        return nmi || (ovf && ovf_en && !mask) || ((ext & ext_en) != 0);
    endfunction

    always @(posedge clk) begin
        m_irq = 0;
        if (!stby_n) m_mode = 5;
        else if (rst) m_mode = 0;
        else if ((m_mode == 0 || m_mode == 2) && sleep && ssel && !dxfer && wsel) m_mode = 3;
        else if (m_mode == 3 && wake_ev()) begin
            if (lsel) begin m_mode = 2; m_irq = 1; end
            else begin m_mode = 4; m_cnt = tbl[ssel_cnt]; m_tgt = msel ? 1 : 0; end
        end else if (m_mode == 4) begin
            m_cnt--;
            if (m_cnt == 0) begin m_mode = m_tgt; m_irq = 1; end
        end
    end

    task automatic chk(string r, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", r, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!finished) begin
            chk({cur, " mode"}, int'(mode), m_mode);
            chk({cur, " irq"}, int'(irq), int'(m_irq));
            chk({cur, " clocks"}, int'({cpu_en, per_en, wdt_en}),
                (m_mode == 5) ? 0 : (m_mode >= 3) ? 1 : 7);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep = 1; cyc(1); sleep = 0;
    endtask

    initial begin
        cyc(3); rst = 0; cyc(2);
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset clocks", int'({cpu_en, per_en, wdt_en}), 7);

        cur = "R4";
        ssel = 0; pulse_sleep(); chk("R4 ssel=0", int'(mode), 0); ssel = 1;
        dxfer = 1; pulse_sleep(); chk("R4 dxfer=1", int'(mode), 0); dxfer = 0;
        wsel = 0; pulse_sleep(); chk("R4 wsel=0", int'(mode), 0); wsel = 1;

        cur = "R2";
        pulse_sleep(); chk("R2 enter watch", int'(mode), 3);
        cur = "R3";
        chk("R3 watch clocks", int'({cpu_en, per_en, wdt_en}), 1);

        cur = "R5";
        ext = 5'b01000; cyc(1); ext = 0; chk("R5 disabled line", int'(mode), 3);
        ovf = 1; ovf_en = 1; mask = 1; cyc(1); ovf = 0; chk("R5 masked ovf", int'(mode), 3);
        ovf = 1; ovf_en = 0; mask = 0; cyc(1); ovf = 0; chk("R5 ovf disabled", int'(mode), 3);
        cyc(2);
        cur = "R6";
        lsel = 1; ext_en = 5'b01000; ext = 5'b01000; cyc(1); ext = 0; ext_en = 0;
        chk("R6 to sub", int'(mode), 2); chk("R6 irq", int'(irq), 1);
        cyc(1); chk("R6 irq one cycle", int'(irq), 0); lsel = 0;

        cur = "R2";
        pulse_sleep(); chk("R2 from sub", int'(mode), 3);
        cur = "R7";
        ovf = 1; ovf_en = 1; mask = 0; ssel_cnt = 0; cyc(1); ovf = 0; ovf_en = 0;
        chk("R7 settling", int'(mode), 4);
        cyc(7); chk("R7 still settling", int'(mode), 4);
        cyc(1); chk("R7 high after 8", int'(mode), 0); chk("R7 irq", int'(irq), 1);

        for (int s = 0; s < 8; s++) begin
            cur = (s % 2) ? "R8" : "R7";
            pulse_sleep();
            msel = s[0]; ssel_cnt = 3'(s); nmi = 1; cyc(1); nmi = 0; msel = 0;
            cyc(tbl[s] - 1); chk("R7 settle length", int'(mode), 4);
            cyc(1); chk("R8 target", int'(mode), s % 2);
            cur = "R4";
            if (s % 2) begin pulse_sleep(); chk("R4 sleep in medium", int'(mode), 1); end
            rst = 1; cyc(1); rst = 0;
        end

        cur = "R10";
        pulse_sleep(); rst = 1; cyc(1); rst = 0; chk("R10 reset in watch", int'(mode), 0);
        pulse_sleep(); ssel_cnt = 7; nmi = 1; cyc(1); nmi = 0; cyc(50);
        rst = 1; cyc(1); rst = 0; chk("R10 reset in settle", int'(mode), 0);
        chk("R10 no irq", int'(irq), 0);

        cur = "R11";
        pulse_sleep(); nmi = 1; rst = 1; cyc(1); nmi = 0; rst = 0;
        chk("R11 reset beats wake", int'(mode), 0); chk("R11 irq low", int'(irq), 0);
        pulse_sleep(); nmi = 1; lsel = 1; stby_n = 0; cyc(1); nmi = 0; lsel = 0;
        chk("R11 standby beats wake", int'(mode), 5);
        cur = "R9";
        stby_n = 1; cyc(3); chk("R9 hold standby", int'(mode), 5);
        chk("R9 clocks off", int'({cpu_en, per_en, wdt_en}), 0);
        rst = 1; cyc(1); rst = 0; chk("R9 reset exits", int'(mode), 0);
        cur = "R11";
        stby_n = 0; rst = 1; cyc(1); chk("R11 standby beats reset", int'(mode), 5);
        stby_n = 1; cyc(1); rst = 0; cyc(2);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule